// File: doc/BRIEF.md
# Enumeration Resource Allocator Engine

This engine assigns base addresses to the base address registers (BARs) of every function found on a configuration bus. It does the job boot firmware would otherwise do. After a `go` pulse it steps through every slot in order: bus number is the outer loop and device/function number is the inner loop. For each slot it presents the slot coordinates on `slot_bus`/`slot_devfn`. An external description source answers combinationally with a presence flag, the 16-bit class code, and the size and address-space type of each BAR. The source must hold these answers stable for as long as the slot coordinates do not change.

For every implemented BAR, the engine takes an address from one of two cursors, one for I/O space and one for memory space. It aligns that cursor up to the region's own size, writes the result to the BAR, and then moves the cursor past the region. After each BAR write it also writes the low byte of the function's command register, to turn on decoding for the space just assigned. Mass-storage controllers (class code 0x0101) do not use the cursors. They receive the four fixed compatibility port addresses instead.

Every write leaves through a single valid/ready configuration request port. The engine raises `cfg_valid` and holds the address, data and byte enables steady until the port raises `cfg_ready`. A transfer happens on a clock edge where both are high. The engine issues its next request only after the current one has been accepted, so the port can stall the walk for any number of cycles without losing or reordering a write. `done` pulses once when the walk ends.

Top module: `enum_alloc_engine`

## Requirements
- R1: Every accepted `go` reloads the I/O cursor to 0x0000C000 and the memory cursor to 0xF0000000, so two consecutive runs over the same slots produce identical write sequences.
- R2: Slots are visited with bus number ascending as the outer order and device/function number ascending within each bus, over NUM_BUS x NUM_DEVFN slots. A slot whose `slot_present` is low produces no write.
- R3: BARs of a present non-legacy function are handled in index order 0 to NUM_BAR-1. A BAR with nonzero size (assumed a power of two) uses the I/O cursor when its `bar_is_io` bit is 1 and the memory cursor when it is 0. The cursor is first rounded up as (cursor + size - 1) & ~(size - 1), that value is written, and the cursor then becomes that value plus size. A BAR of size zero is skipped.
- R4: A function whose `slot_class` equals 0x0101 (base class in bits 15:8, subclass in bits 7:0) has BAR0 to BAR3 written with 0x1F0, 0x3F4, 0x170 and 0x374, whatever their sizes. Its remaining BARs get no write, and neither cursor moves.
- R5: A BAR write carries `cfg_be` = 4'hF and `cfg_addr` = bit 31 set, bits 30:24 zero, bus in bits 23:16, device/function in bits 15:8, and register offset 0x10 + 4 x index in bits 7:0.
- R6: Each BAR write is followed directly by a command-register write to offset 0x04 of the same function, with `cfg_be` = 4'b0001. Its data holds bit 0 set if any I/O BAR of that function has been written so far, bit 1 set if any memory BAR has, and all other bits zero.
- R7: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and `cfg_addr`, `cfg_data` and `cfg_be` keep their values. Each request is transferred exactly once.
- R8: `busy` rises on the clock edge that accepts `go`. `done` is high for exactly one cycle after the last slot is processed, and `busy` is low on the following cycle.
- R9: A `go` pulse that arrives while `busy` is high is ignored: the write sequence in progress is neither restarted nor repeated.
- R10: Under reset `busy`, `done` and `cfg_valid` are low. While `busy` is low, no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, honoured only while idle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| slot_bus | output | 8 | Bus number of the slot being examined |
| slot_devfn | output | 8 | Device/function number of the slot being examined |
| slot_present | input | 1 | A function exists at the addressed slot |
| slot_class | input | 16 | Class code of the addressed function (base class, subclass) |
| bar_size | input | NUM_BAR*ADDR_W | Region size per BAR, BAR i in bits i*ADDR_W upward, zero when not implemented |
| bar_is_io | input | NUM_BAR | Per BAR: 1 = I/O space, 0 = memory space |
| cfg_valid | output | 1 | Configuration write request pending |
| cfg_ready | input | 1 | Port accepts the pending request |
| cfg_addr | output | 32 | Enable bit, bus, device/function and register offset |
| cfg_data | output | ADDR_W | Write data |
| cfg_be | output | 4 | Byte enables of the write |

## Verification
Each write is due only at a handshake, so the bench does not predict the cycle of a write. It logs the address, data and byte enables of every transfer, sampled at the falling edge where `cfg_valid` and `cfg_ready` are both high, and afterwards compares the log with a hand-computed table in order. `cfg_ready` is updated just after each rising edge and is throttled in a fixed pattern during one run. At every falling edge the bench confirms that a request stalled at the previous falling edge is still presented unchanged. `busy` is due one edge after `go` is sampled, and the bench looks for it at the next falling edge. `done` is polled at each falling edge, and the bench requires it to have dropped, together with `busy`, at the very next falling edge.

// File: rtl/enum_alloc_pkg.sv
package enum_alloc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_BAR,
    ST_BAR_WR,
    ST_CMD_WR,
    ST_NEXT,
    ST_FINISH
  } eng_state_t;

  // class code that takes fixed compatibility addresses
  localparam logic [15:0] LEGACY_CLASS = 16'h0101;
  localparam int unsigned LEGACY_CNT   = 4;

  // configuration register offsets
  localparam logic [7:0] BAR_OFS_BASE = 8'h10;
  localparam logic [7:0] CMD_OFS      = 8'h04;

  // command register enables
  localparam logic [1:0] CMD_IO_EN  = 2'b01;
  localparam logic [1:0] CMD_MEM_EN = 2'b10;

  function automatic logic [31:0] legacy_base(input int unsigned idx);
    case (idx)
      0:       legacy_base = 32'h0000_01F0;
      1:       legacy_base = 32'h0000_03F4;
      2:       legacy_base = 32'h0000_0170;
      default: legacy_base = 32'h0000_0374;
    endcase
  endfunction

endpackage

// File: rtl/slot_walker.sv
module slot_walker #(
  parameter int NUM_BUS   = 256,
  parameter int NUM_DEVFN = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  output logic [7:0] bus,
  output logic [7:0] devfn,
  output logic       last
);
  localparam logic [7:0] LAST_BUS   = 8'(NUM_BUS - 1);
  localparam logic [7:0] LAST_DEVFN = 8'(NUM_DEVFN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      bus   <= '0;
      devfn <= '0;
    end else if (step) begin
      if (devfn == LAST_DEVFN) begin
        devfn <= '0;
        bus   <= bus + 8'd1;
      end else begin
        devfn <= devfn + 8'd1;
      end
    end
  end

  assign last = (bus == LAST_BUS) && (devfn == LAST_DEVFN);
endmodule

// File: rtl/bar_cursor.sv
module bar_cursor #(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] START = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] size,
  input  logic              commit,
  output logic [ADDR_W-1:0] aligned
);
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask    = size - ADDR_W'(1);
    aligned = (cur + mask) & ~mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) cur <= START;
    else if (commit)    cur <= aligned + size;
  end
endmodule

// File: rtl/cfg_req_reg.sv
module cfg_req_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [31:0]       ld_addr,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic [3:0]        ld_be,
  input  logic              ready,
  output logic              valid,
  output logic [31:0]       addr,
  output logic [ADDR_W-1:0] data,
  output logic [3:0]        be,
  output logic              accepted
);
  assign accepted = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
      be    <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
      be    <= ld_be;
    end else if (accepted) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/enum_alloc_engine.sv
module enum_alloc_engine
  import enum_alloc_pkg::*;
#(
  parameter int              NUM_BUS   = 256,
  parameter int              NUM_DEVFN = 256,
  parameter int              NUM_BAR   = 6,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] IO_START  = ADDR_W'(32'h0000_C000),
  parameter logic [ADDR_W-1:0] MEM_START = ADDR_W'(32'hF000_0000)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  output logic                      busy,
  output logic                      done,
  output logic [7:0]                slot_bus,
  output logic [7:0]                slot_devfn,
  input  logic                      slot_present,
  input  logic [15:0]               slot_class,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_size,
  input  logic [NUM_BAR-1:0]        bar_is_io,
  output logic                      cfg_valid,
  input  logic                      cfg_ready,
  output logic [31:0]               cfg_addr,
  output logic [ADDR_W-1:0]         cfg_data,
  output logic [3:0]                cfg_be
);
  localparam int IDX_W = $clog2(NUM_BAR + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_BAR);
  localparam logic [IDX_W-1:0] IDX_LEG = IDX_W'(LEGACY_CNT);

  eng_state_t        state;
  logic [IDX_W-1:0]  bar_idx;
  logic [1:0]        cmd_bits;

  logic              start, step, walk_last, accepted;
  logic              load_bar, load_cmd, load;
  logic              is_legacy, idx_ok, want_write;
  logic [ADDR_W-1:0] cur_size, io_aligned, mem_aligned, bar_value, legacy_value;
  logic              cur_io;
  logic              io_commit, mem_commit;
  logic [7:0]        reg_ofs;
  logic [31:0]       ld_addr;
  logic [ADDR_W-1:0] ld_data;
  logic [3:0]        ld_be;

  // per-BAR selection
  always_comb begin
    cur_size     = '0;
    cur_io       = 1'b0;
    legacy_value = '0;
    for (int i = 0; i < NUM_BAR; i++) begin
      if (bar_idx == IDX_W'(i)) begin
        cur_size     = bar_size[i*ADDR_W +: ADDR_W];
        cur_io       = bar_is_io[i];
        legacy_value = ADDR_W'(legacy_base(i));
      end
    end
  end

  always_comb begin
    is_legacy  = (slot_class == LEGACY_CLASS);
    idx_ok     = (bar_idx != IDX_END);
    want_write = is_legacy ? (bar_idx < IDX_LEG) : (cur_size != '0);
    bar_value  = is_legacy ? legacy_value : (cur_io ? io_aligned : mem_aligned);
    load_bar   = (state == ST_BAR) && idx_ok && want_write;
    load_cmd   = (state == ST_BAR_WR) && accepted;
    load       = load_bar || load_cmd;
    io_commit  = load_bar && !is_legacy && cur_io;
    mem_commit = load_bar && !is_legacy && !cur_io;
    start      = (state == ST_IDLE) && go;
    step       = (state == ST_NEXT) && !walk_last;
    reg_ofs    = load_cmd ? CMD_OFS : 8'(BAR_OFS_BASE + 8'(bar_idx) * 8'd4);
    ld_addr    = {1'b1, 7'd0, slot_bus, slot_devfn, reg_ofs};
    ld_data    = load_cmd ? ADDR_W'(cmd_bits) : bar_value;
    ld_be      = load_cmd ? 4'b0001 : 4'b1111;
  end

  slot_walker #(.NUM_BUS(NUM_BUS), .NUM_DEVFN(NUM_DEVFN)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (step),
    .bus   (slot_bus),
    .devfn (slot_devfn),
    .last  (walk_last)
  );

  bar_cursor #(.ADDR_W(ADDR_W), .START(IO_START)) u_io_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (start),
    .size    (cur_size),
    .commit  (io_commit),
    .aligned (io_aligned)
  );

  bar_cursor #(.ADDR_W(ADDR_W), .START(MEM_START)) u_mem_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (start),
    .size    (cur_size),
    .commit  (mem_commit),
    .aligned (mem_aligned)
  );

  cfg_req_reg #(.ADDR_W(ADDR_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .ld_be    (ld_be),
    .ready    (cfg_ready),
    .valid    (cfg_valid),
    .addr     (cfg_addr),
    .data     (cfg_data),
    .be       (cfg_be),
    .accepted (accepted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bar_idx  <= '0;
      cmd_bits <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (go) state <= ST_SCAN;
        ST_SCAN: begin
          bar_idx  <= '0;
          cmd_bits <= '0;
          state    <= slot_present ? ST_BAR : ST_NEXT;
        end
        ST_BAR: begin
          if (!idx_ok) begin
            state <= ST_NEXT;
          end else if (want_write) begin
            cmd_bits <= cmd_bits | (cur_io ? CMD_IO_EN : CMD_MEM_EN);
            state    <= ST_BAR_WR;
          end else begin
            bar_idx <= bar_idx + IDX_W'(1);
          end
        end
        ST_BAR_WR: if (accepted) state <= ST_CMD_WR;
        ST_CMD_WR: if (accepted) begin
          bar_idx <= bar_idx + IDX_W'(1);
          state   <= ST_BAR;
        end
        ST_NEXT:   state <= walk_last ? ST_FINISH : ST_SCAN;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
endmodule

// File: rtl/enum_alloc_checker.sv
module enum_alloc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [7:0]        slot_bus,
  input logic [7:0]        slot_devfn,
  input logic              slot_present,
  input logic [15:0]       slot_class,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [31:0]       cfg_addr,
  input logic [ADDR_W-1:0] cfg_data,
  input logic [3:0]        cfg_be
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_data) && $stable(cfg_be));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_bar_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_be == 4'hF |-> cfg_addr[31] && cfg_addr[30:24] == 7'd0 &&
      cfg_addr[1:0] == 2'd0 && cfg_addr[7:0] >= 8'h10);

  p_slot_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_addr[23:16] == slot_bus && cfg_addr[15:8] == slot_devfn);

  p_cmd_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_be == 4'h1 |-> cfg_addr[7:0] == 8'h04 &&
      cfg_data[ADDR_W-1:2] == '0 && cfg_data[1:0] != 2'b00);

  p_legacy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && slot_present && slot_class == 16'h0101 && cfg_be == 4'hF |->
      cfg_data == ADDR_W'(32'h1F0) || cfg_data == ADDR_W'(32'h3F4) ||
      cfg_data == ADDR_W'(32'h170) || cfg_data == ADDR_W'(32'h374));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_valid);
endmodule

bind enum_alloc_engine enum_alloc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .slot_bus     (slot_bus),
  .slot_devfn   (slot_devfn),
  .slot_present (slot_present),
  .slot_class   (slot_class),
  .cfg_valid    (cfg_valid),
  .cfg_ready    (cfg_ready),
  .cfg_addr     (cfg_addr),
  .cfg_data     (cfg_data),
  .cfg_be       (cfg_be)
);

// File: tb/sim_enum_alloc_engine.sv
module sim_enum_alloc_engine;
  localparam int NB = 6;
  localparam int AW = 32;
  localparam int NEXP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic busy, done, slot_present, cfg_valid;
  logic cfg_ready = 1'b1;
  logic [7:0] slot_bus, slot_devfn;
  logic [15:0] slot_class;
  logic [NB*AW-1:0] bar_size;
  logic [NB-1:0] bar_is_io;
  logic [31:0] cfg_addr;
  logic [AW-1:0] cfg_data;
  logic [3:0] cfg_be;

  int checks = 0;
  int fails = 0;
  int nlog = 0;
  int done_cnt = 0;
  int cyc = 0;
  bit throttle = 1'b0;
  logic [67:0] got [0:31];
  logic        prev_stall = 1'b0;
  logic [67:0] prev_req = '0;

  // expected writes {addr, data, be}, hand-computed from R1..R6
  localparam logic [67:0] EXP [NEXP] = '{
    {32'h8000_0010, 32'hF000_0000, 4'hF}, {32'h8000_0004, 32'h0000_0002, 4'h1},
    {32'h8000_0210, 32'h0000_C000, 4'hF}, {32'h8000_0204, 32'h0000_0001, 4'h1},
    {32'h8000_0214, 32'hF010_0000, 4'hF}, {32'h8000_0204, 32'h0000_0003, 4'h1},
    {32'h8000_021C, 32'h0000_C100, 4'hF}, {32'h8000_0204, 32'h0000_0003, 4'h1},
    {32'h8001_0010, 32'h0000_01F0, 4'hF}, {32'h8001_0004, 32'h0000_0001, 4'h1},
    {32'h8001_0014, 32'h0000_03F4, 4'hF}, {32'h8001_0004, 32'h0000_0001, 4'h1},
    {32'h8001_0018, 32'h0000_0170, 4'hF}, {32'h8001_0004, 32'h0000_0001, 4'h1},
    {32'h8001_001C, 32'h0000_0374, 4'hF}, {32'h8001_0004, 32'h0000_0001, 4'h1},
    {32'h8001_0320, 32'h0000_C200, 4'hF}, {32'h8001_0304, 32'h0000_0001, 4'h1},
    {32'h8001_0324, 32'hF020_0000, 4'hF}, {32'h8001_0304, 32'h0000_0003, 4'h1}
  };

  enum_alloc_engine #(.NUM_BUS(2), .NUM_DEVFN(4), .NUM_BAR(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
    .slot_bus(slot_bus), .slot_devfn(slot_devfn), .slot_present(slot_present),
    .slot_class(slot_class), .bar_size(bar_size), .bar_is_io(bar_is_io),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_be(cfg_be)
  );

  always #4 clk = ~clk;

  // slot description model
  always_comb begin
    slot_present = 1'b0;
    slot_class   = 16'h0000;
    bar_size     = '0;
    bar_is_io    = '0;
    case ({slot_bus, slot_devfn})
      16'h0000: begin
        slot_present = 1'b1; slot_class = 16'h0600;
        bar_size[0*AW +: AW] = 32'h1000;
      end
      16'h0002: begin
        slot_present = 1'b1; slot_class = 16'h0200;
        bar_size[0*AW +: AW] = 32'h20;     bar_is_io[0] = 1'b1;
        bar_size[1*AW +: AW] = 32'h10_0000;
        bar_size[3*AW +: AW] = 32'h100;    bar_is_io[3] = 1'b1;
      end
      16'h0100: begin
        slot_present = 1'b1; slot_class = 16'h0101; bar_is_io = 6'h3F;
        bar_size[0*AW +: AW] = 32'h8; bar_size[1*AW +: AW] = 32'h4;
        bar_size[2*AW +: AW] = 32'h8; bar_size[3*AW +: AW] = 32'h4;
        bar_size[4*AW +: AW] = 32'h10;
      end
      16'h0103: begin
        slot_present = 1'b1; slot_class = 16'h0300;
        bar_size[4*AW +: AW] = 32'h4;      bar_is_io[4] = 1'b1;
        bar_size[5*AW +: AW] = 32'h2000;
      end
      default: ;
    endcase
  end

  // ready pattern, changed just after the rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    cfg_ready <= throttle ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!cfg_valid || {cfg_addr, cfg_data, cfg_be} != prev_req) begin
          fails++;
          $display("FAIL R7 stalled request changed: got v=%0b %h exp %h", cfg_valid,
                   {cfg_addr, cfg_data, cfg_be}, prev_req);
        end
      end
      prev_stall = cfg_valid && !cfg_ready;
      prev_req   = {cfg_addr, cfg_data, cfg_be};
      if (cfg_valid && cfg_ready) begin
        if (nlog < 32) got[nlog] = {cfg_addr, cfg_data, cfg_be};
        nlog++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_go();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R8 done reached", 68'(done), 68'd1);
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle then idle", {66'd0, done, busy}, 68'd0);
  endtask

  task automatic compare_log(input string tag);
    chk(nlog == NEXP, {tag, " R2 write count"}, 68'(nlog), 68'(NEXP));
    for (int i = 0; i < NEXP; i++) begin
      string r;
      if (EXP[i][3:0] == 4'h1) r = "R6";
      else if (EXP[i][67:52] == 16'h8001 && EXP[i][51:44] == 8'h00) r = "R4";
      else r = "R3/R5";
      chk(got[i] == EXP[i], {tag, " ", r}, got[i], EXP[i]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy, "R10 busy in reset", 68'(busy), 68'd0);
    chk(!done, "R10 done in reset", 68'(done), 68'd0);
    chk(!cfg_valid, "R10 cfg_valid in reset", 68'(cfg_valid), 68'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cfg_valid && nlog == 0, "R10 quiet while idle", 68'(nlog), 68'd0);

    // run 1: free-flowing port
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    chk(busy, "R8 busy after go", 68'(busy), 68'd1);
    chk(slot_bus == 8'd0 && slot_devfn == 8'd0, "R2 walk starts at slot 0",
        {52'd0, slot_bus, slot_devfn}, 68'd0);
    wait_done();
    compare_log("run1");
    chk(done_cnt == 1, "R8 single done pulse", 68'(done_cnt), 68'd1);

    // run 2: throttled port, extra go while busy (R9), same result (R1)
    nlog = 0; done_cnt = 0; throttle = 1'b1;
    pulse_go();
    repeat (6) @(negedge clk);
    pulse_go();
    repeat (17) @(negedge clk);
    pulse_go();
    wait_done();
    compare_log("run2 R1 R9");
    chk(done_cnt == 1, "R9 no restart after busy go", 68'(done_cnt), 68'd1);

    // R10: nothing happens after the walk
    repeat (20) @(negedge clk);
    chk(nlog == NEXP && !busy, "R10 no request while idle", 68'(nlog), 68'(NEXP));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule